// File: doc/BRIEF.md
# Vectored Interrupt Address Unit

This block stands between the masked IRQ status vector of an interrupt controller and the CPU. It turns whichever IRQ sources are pending into the address of the handler the CPU should jump to. Software fills a table of sixteen vector slots. Each slot holds a handler address, the number of the source it serves and an enable bit. Slot 0 has the highest priority. Sources that no enabled slot claims fall back to a programmable default handler address.

The current-vector register has a side effect when it is read. The read returns the handler address, and it also records that the CPU has entered that handler, so the in-service priority level drops to the level of that slot. A non-vectored entry goes to a level below every slot. The previous level is kept on a small stack. Any write to the same register ends the handler and restores the previous level. While a handler runs, the IRQ output to the CPU is masked: only slots of strictly higher priority can raise it again, which gives nested preemption.

The register interface is APB-style with zero wait states, and `prdata` follows `paddr` combinationally. Reset is synchronous and active high.

Top module: `vaddr_unit`

## Requirements
- R1: After reset, every slot address and control register reads 0, the default address reads 0, the current-vector register reads 0, and the unit is idle, with no handler in service.
- R2: Slot k's handler address is read and written at byte offset 0x100+4k. Its control word is at 0x200+4k, with the source number in bits 4:0 and the enable bit in bit 5. Control bits above bit 5 ignore writes and read back 0.
- R3: A read of the current-vector register at offset 0x30 returns the handler address of the lowest-numbered enabled slot whose source bit is set in `irq_status`, considering only slots numbered below the level in service.
- R4: When no such slot exists, a read at 0x30 returns the default address. The default address is read and written at offset 0x34.
- R5: A read at 0x30 that finds a qualifying slot makes that slot's number the in-service level. If no slot qualifies, some status bit is set and the unit is idle, the read enters the non-vectored level, which ranks below slot 15. In every other case the read leaves the level unchanged. No other access changes the level.
- R6: While slot j is in service, only slots numbered below j can be selected or raise `irq_o`. An entry into such a slot nests, and it does not discard j.
- R7: Any write at 0x30, whatever its data, returns the in-service level to the one that held before the most recent entry. A write at 0x30 while idle changes nothing.
- R8: `irq_o` is high exactly when a read at 0x30 would enter a new level. It is therefore low when `irq_status` is zero or when slot 0 is in service.
- R9: Reads of undefined or misaligned offsets return 0. This includes 0x38, slot offsets from 16 upward and 0x31. Writes to such offsets change no register.
- R10: A slot whose enable bit is 0 never matches, even when its source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq_status | input | 32 | Masked IRQ status, one bit per source |
| irq_o | output | 1 | IRQ request to the CPU, masked by the in-service level |

## Verification
The bench sweeps every single pending source and then every pair of pending sources against a slot table with scrambled source numbers and one disabled slot. Single sources separate vectored hits from default fallbacks and from the disabled slot. Pairs separate the priority order from the source order. A long pseudo-random mix of status changes, entry reads and acknowledge writes drives the unit through deep nesting, idle acknowledges and masked requests. A directed nesting sequence and probes at unmapped offsets cover preemption, unwinding and address holes.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

    localparam int unsigned REG_AW  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned IDX_W   = 6;

    localparam logic [REG_AW-1:0] OFF_CUR = 12'h030;
    localparam logic [REG_AW-1:0] OFF_DEF = 12'h034;
    localparam logic [3:0]        PAGE_SADDR = 4'h1;
    localparam logic [3:0]        PAGE_SCTRL = 4'h2;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CUR,
        REG_DEF,
        REG_SADDR,
        REG_SCTRL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [IDX_W-1:0]   idx;
    } apb_dec_t;

    // Map a byte address onto a register selector; misaligned is a hole.
    function automatic apb_dec_t decode_addr(input logic [REG_AW-1:0] a,
                                             input int unsigned nslot);
        apb_dec_t d;
        d.sel = REG_NONE;
        d.idx = a[IDX_W+1:2];
        if (a[1:0] == 2'b00) begin
            if (a == OFF_CUR)
                d.sel = REG_CUR;
            else if (a == OFF_DEF)
                d.sel = REG_DEF;
            else if (a[11:8] == PAGE_SADDR && 32'(a[IDX_W+1:2]) < nslot)
                d.sel = REG_SADDR;
            else if (a[11:8] == PAGE_SCTRL && 32'(a[IDX_W+1:2]) < nslot)
                d.sel = REG_SCTRL;
        end
        return d;
    endfunction

endpackage

// File: rtl/vaddr_slot_bank.sv
module vaddr_slot_bank
    import vaddr_pkg::*;
#(
    parameter int unsigned NSLOT = 16,
    parameter int unsigned NSRC  = 32,
    localparam int unsigned SRC_W = $clog2(NSRC)
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  apb_dec_t                      dec,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NSRC-1:0]               irq_status,
    output logic [NSLOT-1:0][DATA_W-1:0]  slot_addr,
    output logic [NSLOT-1:0][SRC_W-1:0]   slot_src,
    output logic [NSLOT-1:0]              slot_en,
    output logic [NSLOT-1:0]              hit
);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic sel_addr;
        logic sel_ctrl;

        assign sel_addr = wr_en && dec.sel == REG_SADDR && dec.idx == IDX_W'(k);
        assign sel_ctrl = wr_en && dec.sel == REG_SCTRL && dec.idx == IDX_W'(k);

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_addr[k] <= '0;
                slot_src[k]  <= '0;
                slot_en[k]   <= 1'b0;
            end else begin
                if (sel_addr)
                    slot_addr[k] <= wdata;
                if (sel_ctrl) begin
                    slot_src[k] <= wdata[SRC_W-1:0];
                    slot_en[k]  <= wdata[SRC_W];
                end
            end
        end

        assign hit[k] = slot_en[k] & irq_status[slot_src[k]];
    end

endmodule

// File: rtl/vaddr_prio_pick.sv
module vaddr_prio_pick #(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
)(
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

endmodule

// File: rtl/vaddr_level_stack.sv
module vaddr_level_stack #(
    parameter int unsigned DEPTH = 17,
    parameter int unsigned LW    = 5,
    parameter int unsigned IDLE  = 17,
    localparam int unsigned PW = $clog2(DEPTH + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [LW-1:0] push_lvl,
    input  logic          pop,
    output logic [LW-1:0] cur_lvl
);

    logic [DEPTH-1:0][LW-1:0] stk;
    logic [PW-1:0]            sp;

    // Levels only ever decrease on push, so DEPTH entries cannot overflow.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl <= LW'(IDLE);
            sp      <= '0;
            stk     <= '0;
        end else if (push) begin
            stk[sp] <= cur_lvl;
            sp      <= sp + 1'b1;
            cur_lvl <= push_lvl;
        end else if (pop && sp != '0) begin
            cur_lvl <= stk[sp - 1'b1];
            sp      <= sp - 1'b1;
        end
    end

endmodule

// File: rtl/vaddr_unit.sv
module vaddr_unit
    import vaddr_pkg::*;
#(
    parameter int unsigned NSLOT = 16,
    parameter int unsigned NSRC  = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [NSRC-1:0]   irq_status,
    output logic              irq_o
);

    localparam int unsigned SRC_W    = $clog2(NSRC);
    localparam int unsigned IW       = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int unsigned LVL_DEF  = NSLOT;
    localparam int unsigned LVL_IDLE = NSLOT + 1;
    localparam int unsigned LW       = $clog2(NSLOT + 2);

    apb_dec_t                       dec;
    logic                           wr_en;
    logic                           rd_en;
    logic                           vec_rd;
    logic                           vec_ack;
    logic [DATA_W-1:0]              def_addr;
    logic [NSLOT-1:0][DATA_W-1:0]   slot_addr;
    logic [NSLOT-1:0][SRC_W-1:0]    slot_src;
    logic [NSLOT-1:0]               slot_en;
    logic [NSLOT-1:0]               hit;
    logic [NSLOT-1:0]               elig;
    logic                           found;
    logic [IW-1:0]                  win;
    logic [LW-1:0]                  cur_level;
    logic                           def_ok;
    logic                           enter;
    logic [LW-1:0]                  enter_lvl;
    logic [DATA_W-1:0]              vect_addr;

    assign dec     = decode_addr(paddr, NSLOT);
    assign wr_en   = psel & penable & pwrite;
    assign rd_en   = psel & penable & ~pwrite;
    assign vec_rd  = rd_en && dec.sel == REG_CUR;
    assign vec_ack = wr_en && dec.sel == REG_CUR;

    always_ff @(posedge clk) begin
        if (rst)
            def_addr <= '0;
        else if (wr_en && dec.sel == REG_DEF)
            def_addr <= pwdata;
    end

    vaddr_slot_bank #(.NSLOT(NSLOT), .NSRC(NSRC)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .dec        (dec),
        .wdata      (pwdata),
        .irq_status (irq_status),
        .slot_addr  (slot_addr),
        .slot_src   (slot_src),
        .slot_en    (slot_en),
        .hit        (hit)
    );

    // Only slots strictly above the in-service level may compete.
    for (genvar k = 0; k < NSLOT; k++) begin : g_elig
        assign elig[k] = hit[k] && (cur_level > LW'(k));
    end

    vaddr_prio_pick #(.N(NSLOT)) u_pick (
        .req   (elig),
        .found (found),
        .idx   (win)
    );

    assign def_ok    = (|irq_status) && (cur_level > LW'(LVL_DEF));
    assign enter     = found | def_ok;
    assign enter_lvl = found ? LW'(win) : LW'(LVL_DEF);
    assign vect_addr = found ? slot_addr[win] : def_addr;
    assign irq_o     = enter;

    vaddr_level_stack #(.DEPTH(NSLOT + 1), .LW(LW), .IDLE(LVL_IDLE)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (vec_rd && enter),
        .push_lvl (enter_lvl),
        .pop      (vec_ack),
        .cur_lvl  (cur_level)
    );

    always_comb begin
        unique case (dec.sel)
            REG_CUR:   prdata = vect_addr;
            REG_DEF:   prdata = def_addr;
            REG_SADDR: prdata = slot_addr[dec.idx[IW-1:0]];
            REG_SCTRL: prdata = DATA_W'({slot_en[dec.idx[IW-1:0]],
                                         slot_src[dec.idx[IW-1:0]]});
            default:   prdata = '0;
        endcase
    end

endmodule

// File: rtl/vaddr_unit_chk.sv
module vaddr_unit_chk #(
    parameter int unsigned NSLOT = 16,
    parameter int unsigned NSRC  = 32,
    parameter int unsigned LW    = 5
)(
    input logic            clk,
    input logic            rst,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic [11:0]     paddr,
    input logic [31:0]     prdata,
    input logic [NSRC-1:0] irq_status,
    input logic            irq_o,
    input logic [LW-1:0]   cur_level
);

    localparam logic [LW-1:0] IDLE = LW'(NSLOT + 1);

    logic acc_cur;
    logic rd_cur;
    logic wr_cur;
    logic mapped;

    assign acc_cur = psel && penable && paddr == 12'h030;
    assign rd_cur  = acc_cur && !pwrite;
    assign wr_cur  = acc_cur && pwrite;
    assign mapped  = paddr[1:0] == 2'b00 &&
                     (paddr == 12'h030 || paddr == 12'h034 ||
                      ((paddr[11:8] == 4'h1 || paddr[11:8] == 4'h2) &&
                       32'(paddr[7:2]) < NSLOT));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cur_level == IDLE);

    p_entry_deepens_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_cur && irq_o) |=> cur_level < $past(cur_level));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !acc_cur |=> $stable(cur_level));

    p_top_slot_masks_r6: assert property (@(posedge clk) disable iff (rst)
        cur_level == '0 |-> !irq_o);

    p_ack_unwinds_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_cur && cur_level != IDLE) |=> cur_level > $past(cur_level));

    p_ack_idle_noop_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_cur && cur_level == IDLE) |=> cur_level == IDLE);

    p_quiet_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        irq_status == '0 |-> !irq_o);

    p_idle_pending_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_level == IDLE && irq_status != '0) |-> irq_o);

    p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && !mapped) |-> prdata == '0);

endmodule

bind vaddr_unit vaddr_unit_chk #(
    .NSLOT (NSLOT),
    .NSRC  (NSRC),
    .LW    (LW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .prdata     (prdata),
    .irq_status (irq_status),
    .irq_o      (irq_o),
    .cur_level  (cur_level)
);

// File: tb/vaddr_unit_bench.sv
`timescale 1ns/1ps
module vaddr_unit_bench;

    localparam int NSLOT = 16;
    localparam int NSRC  = 32;
    localparam int LDEF  = NSLOT;
    localparam int LIDLE = NSLOT + 1;
    localparam logic [31:0] DEFV = 32'hDEF0_0A00;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic [31:0] irq_status;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the slot table and the in-service level stack.
    logic [31:0] m_addr [NSLOT];
    int          m_src  [NSLOT];
    bit          m_en   [NSLOT];
    int          m_lvl;
    int          m_stk  [32];
    int          m_sp;
    logic [31:0] lf = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    vaddr_unit u_vaddr_unit (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_status(irq_status), .irq_o(irq_o)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #0.5 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic model_pick(output bit fnd, output int w);
        fnd = 1'b0; w = 0;
        for (int k = NSLOT - 1; k >= 0; k--)
            if (m_en[k] && irq_status[m_src[k]] && k < m_lvl) begin
                fnd = 1'b1; w = k;
            end
    endtask

    task automatic check_irq(input string tag);
        bit fnd; int w; logic exp;
        model_pick(fnd, w);
        exp = fnd || (irq_status != 0 && m_lvl > LDEF);
        #0.5 chk(tag, {31'b0, irq_o}, {31'b0, exp});
    endtask

    task automatic set_status(input logic [31:0] v, input string tag);
        @(negedge clk);
        irq_status = v;
        check_irq(tag);
    endtask

    task automatic vec_read(input string tag);
        bit fnd; int w; logic [31:0] d; logic [31:0] exp; string t;
        model_pick(fnd, w);
        exp = fnd ? m_addr[w] : DEFV;
        t = tag;
        if (t == "") t = fnd ? "R3" : (m_en[7] && 0 ? "R10" : "R4");
        apb_rd(12'h030, d);
        chk(t, d, exp);
        if (fnd) begin
            m_stk[m_sp] = m_lvl; m_sp++; m_lvl = w;
        end else if (irq_status != 0 && m_lvl > LDEF) begin
            m_stk[m_sp] = m_lvl; m_sp++; m_lvl = LDEF;
        end
        check_irq("R5");
    endtask

    task automatic vec_ack(input logic [31:0] junk);
        apb_wr(12'h030, junk);
        if (m_sp > 0) begin
            m_sp--; m_lvl = m_stk[m_sp];
        end
        check_irq("R7");
    endtask

    task automatic unwind();
        while (m_sp > 0) vec_ack(32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] d;
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        irq_status = '0; rst = 1'b1;
        m_lvl = LIDLE; m_sp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check_irq("R1");
        apb_rd(12'h030, d); chk("R1 cur", d, 32'h0);
        apb_rd(12'h034, d); chk("R1 def", d, 32'h0);
        for (int k = 0; k < NSLOT; k += 5) begin
            apb_rd(12'h100 + 12'(4 * k), d); chk("R1 slot addr", d, 32'h0);
            apb_rd(12'h200 + 12'(4 * k), d); chk("R1 slot ctrl", d, 32'h0);
        end

        // R2: program the table; scrambled sources, slot 7 disabled (R10)
        apb_wr(12'h034, DEFV);
        apb_rd(12'h034, d); chk("R4 def rw", d, DEFV);
        for (int k = 0; k < NSLOT; k++) begin
            m_addr[k] = 32'h8000_0010 | (32'(k) << 8) | (32'(k) << 20);
            m_src[k]  = (k * 5 + 3) % NSRC;
            m_en[k]   = (k != 7);
            apb_wr(12'h100 + 12'(4 * k), m_addr[k]);
            apb_wr(12'h200 + 12'(4 * k), 32'hFFFF_FFC0 & ~32'h20 | 32'(m_src[k]) |
                   (m_en[k] ? 32'h20 : 32'h0));
        end
        for (int k = 0; k < NSLOT; k++) begin
            apb_rd(12'h100 + 12'(4 * k), d); chk("R2 addr", d, m_addr[k]);
            apb_rd(12'h200 + 12'(4 * k), d);
            chk("R2 ctrl", d, 32'(m_src[k]) | (m_en[k] ? 32'h20 : 32'h0));
        end

        // Single-source sweep: source 6 belongs only to disabled slot 7 (R10)
        for (int s = 0; s < NSRC; s++) begin
            set_status(32'h1 << s, "R8");
            vec_read(s == 6 ? "R10" : "");
            vec_ack(32'(s));
        end

        // Pair sweep: priority order independent of source order (R3)
        for (int a = 0; a < NSRC; a++)
            for (int b = a + 1; b < NSRC; b++) begin
                set_status((32'h1 << a) | (32'h1 << b), "R8");
                vec_read("");
                vec_ack(32'h0);
            end

        // Directed nesting: slot 9, then slot 2 preempts, then unwind (R6)
        set_status(32'h1 << m_src[9], "R8");
        vec_read("R6 enter slot9");
        chk("R6 masked", {31'b0, irq_o}, 32'h0);
        set_status((32'h1 << m_src[9]) | (32'h1 << m_src[12]), "R6 lower masked");
        set_status((32'h1 << m_src[9]) | (32'h1 << m_src[2]), "R6 higher raises");
        vec_read("R6 preempt slot2");
        set_status(32'h1 << m_src[9], "R6");
        vec_ack(32'h1234_5678);
        vec_read("R6 back at 9, nothing new");
        vec_ack(32'h0);
        // R7: acknowledge while idle has no effect
        vec_ack(32'hA5A5_A5A5);
        vec_read("R7 idle ack noop");
        vec_ack(32'h0);
        // R4/R5: unmapped source enters default level, then slot preempts
        set_status(32'h1 << 0, "R8");
        vec_read("R4 default");
        set_status((32'h1 << 0) | (32'h1 << m_src[15]), "R6 slot15 over default");
        vec_read("R6 slot15");
        set_status('0, "R8 quiet");
        unwind();

        // R9: holes read zero, writes to holes change nothing
        apb_wr(12'h038, 32'hFFFF_FFFF);
        apb_wr(12'h140, 32'hFFFF_FFFF);
        apb_wr(12'h240, 32'hFFFF_FFFF);
        apb_wr(12'h031, 32'hFFFF_FFFF);
        apb_wr(12'h101, 32'hFFFF_FFFF);
        apb_rd(12'h038, d); chk("R9 hole 038", d, 32'h0);
        apb_rd(12'h140, d); chk("R9 hole 140", d, 32'h0);
        apb_rd(12'h240, d); chk("R9 hole 240", d, 32'h0);
        apb_rd(12'h031, d); chk("R9 misaligned", d, 32'h0);
        apb_rd(12'h034, d); chk("R9 def kept", d, DEFV);
        apb_rd(12'h100, d); chk("R9 slot0 kept", d, m_addr[0]);
        apb_rd(12'h200, d); chk("R9 ctrl0 kept", d, 32'(m_src[0]) | 32'h20);

        // Pseudo-random mix of status changes, entries and acknowledges
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
            case (lf[1:0])
                2'd0: set_status(lf & {lf[15:0], lf[31:16]} &
                                 {lf[7:0], lf[31:8]}, "R8");
                2'd1, 2'd2: vec_read("");
                default: vec_ack(lf);
            endcase
        end
        set_status('0, "R8");
        unwind();

        finish_run();
    end

endmodule